// File: doc/BRIEF.md
# Radio Transceiver SPI Transaction Engine

This block is a hardware SPI master that carries out whole transactions with a packet radio transceiver. A host hands it one command per transaction. The command carries an operation code, a register address, a payload length and a receive capacity. The engine then drives chip select, the serial clock and MOSI, and samples MISO. Write payload bytes are pulled from the host through a valid/ready handshake. Received bytes come back one at a time with a valid strobe. A one-cycle done pulse reports the number of bytes returned.

Four operations are supported: register write, register read, frame-buffer write and frame-buffer read. For a frame-buffer read, the first byte received is a length. The engine adds one to it for a trailing link-quality byte and limits the result to the host's capacity. It then returns exactly that many bytes. The command prefixes and the serial clock divider are parameters.

The block also brings an asynchronous interrupt level from the transceiver into the system clock domain through two flops.

Top module: `radioSpiEngine`

## Requirements
- R1: Every byte is shifted most significant bit first, with exactly eight serial clock pulses per byte. The serial clock idles low, and MOSI does not change while the serial clock is high.
- R2: `spiCsN` falls when a command is accepted and stays low until after the last byte. The serial clock is never high while `spiCsN` is high.
- R3: With `cmdOp`=0 (register write), the engine sends `WR_PFX|cmdAddr` (default 8'hC0), then one byte taken from the write stream. `doneCount` is 0.
- R4: With `cmdOp`=1 (register read), the engine sends `RD_PFX|cmdAddr` (default 8'h80), then clocks in one byte while sending 8'h00. That byte is presented on `rdData` with `rdValid`, and `doneCount` is 1.
- R5: With `cmdOp`=2 (buffer write), the engine sends `BW_CMD` (default 8'h60), then `cmdLen`, then `cmdLen` payload bytes from the write stream in order. A length of 0 ends the transaction after the length byte.
- R6: With `cmdOp`=3 (buffer read), the engine sends `BR_CMD` (default 8'h20) and clocks in a length byte L. It then clocks in N = min(L+1, `cmdCap`) bytes, presents each of them on `rdData`, and reports N on `doneCount`. A capacity of 0 ends the transaction after the length byte.
- R7: `busy` is high from the cycle after acceptance until the cycle in which `done` pulses for one cycle. `cmdValid` is ignored while `busy` is high.
- R8: Write bytes move only on a cycle with `wrValid` and `wrReady` both high. While `wrReady` waits for `wrValid`, the serial clock stays low.
- R9: `irqSync` equals `irqIn` delayed by two system clocks.
- R10: Each serial clock high phase lasts exactly `HALF_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request, accepted when not busy |
| cmdOp | input | 2 | Operation: 0 reg write, 1 reg read, 2 buf write, 3 buf read |
| cmdAddr | input | 8 | Register address, OR-ed into the prefix |
| cmdLen | input | 8 | Payload length for buffer write |
| cmdCap | input | 8 | Receive capacity for buffer read |
| busy | output | 1 | Transaction in progress |
| wrData | input | 8 | Write payload byte |
| wrValid | input | 1 | Write payload byte available |
| wrReady | output | 1 | Engine takes the write byte this cycle if valid |
| rdData | output | 8 | Received byte |
| rdValid | output | 1 | Strobe for rdData |
| done | output | 1 | One-cycle end of transaction pulse |
| doneCount | output | 8 | Bytes returned by the transaction |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the transceiver |
| spiMiso | input | 1 | Serial data from the transceiver |
| irqIn | input | 1 | Asynchronous interrupt level |
| irqSync | output | 1 | Synchronised interrupt level |

## Verification
A wrong stage or remaining count in the control shows up at the serial pins within one byte time. Chip select either rises early or stays low too long, or the captured MOSI stream gains or loses bytes, or it carries a wrong prefix. A fault in the bit shifter shows up as a corrupted received byte on `rdData`, or as a high phase of the wrong length. Either appears within the same byte. Clamp errors in the buffer read are caught by comparing `doneCount` and the number of `rdValid` strobes with min(L+1, capacity) at the done pulse.

// File: rtl/radioSpiPkg.sv
package radioSpiPkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_REG_WR = 2'd0,
    OP_REG_RD = 2'd1,
    OP_BUF_WR = 2'd2,
    OP_BUF_RD = 2'd3
  } radioOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              startByte;
    logic [BYTE_W-1:0] txByte;
  } spiStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic              byteDone;
    logic [BYTE_W-1:0] rxByte;
  } dpStatus_t;
endpackage

// File: rtl/radioSpiDatapath.sv
module radioSpiDatapath
  import radioSpiPkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiStrobe_t strobe,
  output dpStatus_t  status,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  input  logic       irqIn,
  output logic       irqSync
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic              active;
  logic              phaseHigh;
  logic [2:0]        bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] rxReg;
  logic              byteDone;
  logic              irqMeta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      phaseHigh <= 1'b0;
      bitCnt    <= '0;
      divCnt    <= '0;
      shReg     <= '0;
      rxReg     <= '0;
      sclk      <= 1'b0;
      byteDone  <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strobe.startByte) begin
        active    <= 1'b1;
        phaseHigh <= 1'b0;
        bitCnt    <= '0;
        divCnt    <= '0;
        shReg     <= strobe.txByte;
      end else if (active) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!phaseHigh) begin
            rxReg     <= {rxReg[BYTE_W-2:0], miso};
            sclk      <= 1'b1;
            phaseHigh <= 1'b1;
          end else begin
            sclk      <= 1'b0;
            phaseHigh <= 1'b0;
            shReg     <= {shReg[BYTE_W-2:0], 1'b0};
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqMeta <= 1'b0;
      irqSync <= 1'b0;
    end else begin
      irqMeta <= irqIn;
      irqSync <= irqMeta;
    end
  end

  assign mosi            = shReg[BYTE_W-1];
  assign status.byteDone = byteDone;
  assign status.rxByte   = rxReg;

  // R1
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));

  // R1
  no_restart_mid_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startByte |-> !active);
endmodule

// File: rtl/radioSpiCtrl.sv
module radioSpiCtrl
  import radioSpiPkg::*;
#(
  parameter logic [7:0] WR_PFX = 8'hC0,
  parameter logic [7:0] RD_PFX = 8'h80,
  parameter logic [7:0] BW_CMD = 8'h60,
  parameter logic [7:0] BR_CMD = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdAddr,
  input  logic [BYTE_W-1:0] cmdLen,
  input  logic [BYTE_W-1:0] cmdCap,
  output logic              busy,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid,
  output logic              done,
  output logic [BYTE_W-1:0] doneCount,
  output logic              csN,
  output spiStrobe_t        strobe,
  input  dpStatus_t         status
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_END} state_t;
  typedef enum logic [1:0] {ST_CMD, ST_SECOND, ST_BODY} stage_t;

  state_t            state;
  stage_t            stage;
  radioOp_t          op;
  logic [BYTE_W-1:0] addrReg;
  logic [BYTE_W-1:0] lenReg;
  logic [BYTE_W-1:0] capReg;
  logic [BYTE_W-1:0] remain;
  logic [BYTE_W-1:0] countReg;
  logic              needWr;
  logic [BYTE_W:0]   rdTotal;
  logic [BYTE_W-1:0] rdClamped;

  assign busy   = (state != S_IDLE);
  assign needWr = (stage == ST_SECOND && op == OP_REG_WR) ||
                  (stage == ST_BODY   && op == OP_BUF_WR);
  assign wrReady = (state == S_LOAD) && needWr;

  assign rdTotal   = {1'b0, status.rxByte} + 9'd1;
  assign rdClamped = (rdTotal > {1'b0, capReg}) ? capReg : rdTotal[BYTE_W-1:0];

  always_comb begin
    strobe.startByte = (state == S_LOAD) && (!needWr || wrValid);
    strobe.txByte    = '0;
    unique case (stage)
      ST_CMD: begin
        unique case (op)
          OP_REG_WR: strobe.txByte = WR_PFX | addrReg;
          OP_REG_RD: strobe.txByte = RD_PFX | addrReg;
          OP_BUF_WR: strobe.txByte = BW_CMD;
          OP_BUF_RD: strobe.txByte = BR_CMD;
          default:   strobe.txByte = '0;
        endcase
      end
      ST_SECOND: begin
        if (op == OP_REG_WR)      strobe.txByte = wrData;
        else if (op == OP_BUF_WR) strobe.txByte = lenReg;
      end
      ST_BODY: begin
        if (op == OP_BUF_WR) strobe.txByte = wrData;
      end
      default: strobe.txByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      stage     <= ST_CMD;
      op        <= OP_REG_WR;
      addrReg   <= '0;
      lenReg    <= '0;
      capReg    <= '0;
      remain    <= '0;
      countReg  <= '0;
      csN       <= 1'b1;
      rdData    <= '0;
      rdValid   <= 1'b0;
      done      <= 1'b0;
      doneCount <= '0;
    end else begin
      rdValid <= 1'b0;
      done    <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmdValid) begin
            op       <= radioOp_t'(cmdOp);
            addrReg  <= cmdAddr;
            lenReg   <= cmdLen;
            capReg   <= cmdCap;
            countReg <= '0;
            stage    <= ST_CMD;
            csN      <= 1'b0;
            state    <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (strobe.startByte) state <= S_SHIFT;
        end
        S_SHIFT: begin
          if (status.byteDone) begin
            state <= S_LOAD;
            unique case (stage)
              ST_CMD: stage <= ST_SECOND;
              ST_SECOND: begin
                unique case (op)
                  OP_REG_WR: state <= S_END;
                  OP_REG_RD: begin
                    rdData   <= status.rxByte;
                    rdValid  <= 1'b1;
                    countReg <= 8'd1;
                    state    <= S_END;
                  end
                  OP_BUF_WR: begin
                    remain <= lenReg;
                    stage  <= ST_BODY;
                    if (lenReg == '0) state <= S_END;
                  end
                  OP_BUF_RD: begin
                    remain   <= rdClamped;
                    countReg <= rdClamped;
                    stage    <= ST_BODY;
                    if (rdClamped == '0) state <= S_END;
                  end
                  default: state <= S_END;
                endcase
              end
              ST_BODY: begin
                remain <= remain - 1'b1;
                if (op == OP_BUF_RD) begin
                  rdData  <= status.rxByte;
                  rdValid <= 1'b1;
                end
                if (remain == 8'd1) state <= S_END;
              end
              default: state <= S_END;
            endcase
          end
        end
        S_END: begin
          csN       <= 1'b1;
          done      <= 1'b1;
          doneCount <= countReg;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8
  ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> busy);

  // R6
  count_within_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && op == OP_BUF_RD) |-> (doneCount <= capReg));
endmodule

// File: rtl/radioSpiEngine.sv
module radioSpiEngine
  import radioSpiPkg::*;
#(
  parameter int         HALF_DIV = 2,
  parameter logic [7:0] WR_PFX   = 8'hC0,
  parameter logic [7:0] RD_PFX   = 8'h80,
  parameter logic [7:0] BW_CMD   = 8'h60,
  parameter logic [7:0] BR_CMD   = 8'h20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [7:0] cmdAddr,
  input  logic [7:0] cmdLen,
  input  logic [7:0] cmdCap,
  output logic       busy,
  input  logic [7:0] wrData,
  input  logic       wrValid,
  output logic       wrReady,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       done,
  output logic [7:0] doneCount,
  output logic       spiCsN,
  output logic       spiSclk,
  output logic       spiMosi,
  input  logic       spiMiso,
  input  logic       irqIn,
  output logic       irqSync
);
  spiStrobe_t strobe;
  dpStatus_t  status;

  radioSpiCtrl #(
    .WR_PFX(WR_PFX), .RD_PFX(RD_PFX), .BW_CMD(BW_CMD), .BR_CMD(BR_CMD)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdCap(cmdCap), .busy(busy),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .done(done), .doneCount(doneCount),
    .csN(spiCsN), .strobe(strobe), .status(status)
  );

  radioSpiDatapath #(.HALF_DIV(HALF_DIV)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .sclk(spiSclk), .mosi(spiMosi), .miso(spiMiso),
    .irqIn(irqIn), .irqSync(irqSync)
  );

  // R2
  sclk_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  // R2
  read_inside_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !spiCsN);
endmodule

// File: tb/test_radioSpiEngine.sv
module test_radioSpiEngine;
  localparam int HALF_DIV = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [7:0] cmdAddr = '0, cmdLen = '0, cmdCap = '0;
  logic       busy;
  logic [7:0] wrData = '0;
  logic       wrValid = 1'b0;
  logic       wrReady;
  logic [7:0] rdData;
  logic       rdValid;
  logic       done;
  logic [7:0] doneCount;
  logic       spiCsN, spiSclk, spiMosi;
  logic       spiMiso = 1'b0;
  logic       irqIn = 1'b0;
  logic       irqSync;

  int checks = 0;
  int fails = 0;

  byte unsigned misoQ[$];
  byte unsigned payQ[$];
  byte unsigned mosiQ[$];
  byte unsigned rdQ[$];
  int  bitIdx = 0;
  int  nBits = 0;
  logic [7:0] curByte = '0;
  logic mosiAtRise = 1'b0;
  logic prevSclk = 1'b0;
  int  hiCnt = 0;
  logic protoOn = 1'b0;

  always #10 clk = ~clk;

  radioSpiEngine #(.HALF_DIV(HALF_DIV)) i_radioSpiEngine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdCap(cmdCap), .busy(busy),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .done(done), .doneCount(doneCount),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .irqIn(irqIn), .irqSync(irqSync)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic misoBit(input int idx);
    if (idx / 8 < misoQ.size()) return misoQ[idx / 8][7 - (idx % 8)];
    return 1'b0;
  endfunction

  // transceiver model: shift out response bits after each falling clock
  always @(negedge spiSclk) begin
    bitIdx = bitIdx + 1;
    spiMiso = misoBit(bitIdx);
  end

  // capture MOSI on rising serial clock
  always @(posedge spiSclk) begin
    if (!spiCsN) begin
      curByte = {curByte[6:0], spiMosi};
      nBits = nBits + 1;
      if (nBits % 8 == 0) mosiQ.push_back(curByte);
    end
    mosiAtRise = spiMosi;
  end

  // per-clock protocol comparison
  always @(negedge clk) begin
    if (rstN && protoOn) begin
      if (spiCsN) check(spiSclk == 1'b0, "R2 sclk low while deselected", spiSclk, 0);
      if (spiSclk) check(spiMosi == mosiAtRise, "R1 mosi stable while sclk high", spiMosi, mosiAtRise);
      if (spiSclk) hiCnt++;
      if (prevSclk && !spiSclk) begin
        check(hiCnt == HALF_DIV, "R10 high phase length", hiCnt, HALF_DIV);
        hiCnt = 0;
      end
      prevSclk = spiSclk;
      if (rdValid) rdQ.push_back(rdData);
    end
  end

  task automatic runCmd(input logic [1:0] op, input logic [7:0] addr,
                        input logic [7:0] len, input logic [7:0] cap,
                        input int stall, input bit poke, input string tag);
    byte unsigned expMosi[$];
    byte unsigned expRd[$];
    int expCount;
    int wait_n;
    int stallLeft;
    int L, n;
    bit seenDone;
    byte unsigned payCopy[$];
    payCopy = payQ;
    expCount = 0;
    case (op)
      2'd0: begin expMosi.push_back(8'hC0 | addr); expMosi.push_back(payCopy[0]); end
      2'd1: begin expMosi.push_back(8'h80 | addr); expMosi.push_back(8'h00);
                  expRd.push_back(misoQ[1]); expCount = 1; end
      2'd2: begin expMosi.push_back(8'h60); expMosi.push_back(len);
                  for (int i = 0; i < len; i++) expMosi.push_back(payCopy[i]); end
      default: begin
        expMosi.push_back(8'h20); expMosi.push_back(8'h00);
        L = misoQ[1];
        n = (L + 1 > cap) ? cap : L + 1;
        for (int i = 0; i < n; i++) begin expMosi.push_back(8'h00); expRd.push_back(misoQ[2 + i]); end
        expCount = n;
      end
    endcase
    mosiQ.delete(); rdQ.delete(); nBits = 0; bitIdx = 0; spiMiso = misoBit(0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr; cmdLen = len; cmdCap = cap;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, {"R7 busy after accept ", tag}, busy, 1);
    check(spiCsN == 1'b0, {"R2 select low after accept ", tag}, spiCsN, 0);
    stallLeft = stall;
    wait_n = 0;
    seenDone = 0;
    while (!seenDone && wait_n < 40000) begin
      if (poke && wait_n == 5) begin
        cmdValid = 1'b1; cmdOp = ~op; cmdAddr = 8'h3F;
      end else begin
        cmdValid = 1'b0;
      end
      if (wrReady && stallLeft > 0) begin
        wrValid = 1'b0;
        stallLeft--;
        check(spiSclk == 1'b0, {"R8 clock held low while stalled ", tag}, spiSclk, 0);
      end else begin
        wrValid = (payQ.size() > 0);
        wrData  = (payQ.size() > 0) ? payQ[0] : 8'h00;
        if (wrValid && wrReady) void'(payQ.pop_front());
      end
      @(negedge clk);
      wait_n++;
      if (done) begin
        seenDone = 1;
        check(busy == 1'b0, {"R7 busy low at done ", tag}, busy, 0);
        check(doneCount == expCount, {"R6 doneCount ", tag}, doneCount, expCount);
      end
    end
    cmdValid = 1'b0;
    wrValid = 1'b0;
    check(seenDone, {"R7 done seen ", tag}, seenDone, 1);
    repeat (3) begin
      @(negedge clk);
      check(spiCsN == 1'b1, {"R7 no extra transaction ", tag}, spiCsN, 1);
    end
    check(mosiQ.size() == expMosi.size(), {"R2 byte count ", tag}, mosiQ.size(), expMosi.size());
    for (int i = 0; i < expMosi.size() && i < mosiQ.size(); i++)
      check(mosiQ[i] == expMosi[i], {"R1 R3 R5 mosi byte ", tag}, mosiQ[i], expMosi[i]);
    check(rdQ.size() == expRd.size(), {"R4 R6 read strobes ", tag}, rdQ.size(), expRd.size());
    for (int i = 0; i < expRd.size() && i < rdQ.size(); i++)
      check(rdQ[i] == expRd[i], {"R4 R6 read byte ", tag}, rdQ[i], expRd[i]);
    check(nBits % 8 == 0, {"R1 eight clocks per byte ", tag}, nBits % 8, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(spiCsN == 1'b1, "R2 reset select high", spiCsN, 1);
    check(spiSclk == 1'b0, "R1 reset sclk low", spiSclk, 0);
    check(busy == 1'b0, "R7 reset not busy", busy, 0);
    check(done == 1'b0, "R7 reset no done", done, 0);
    check(wrReady == 1'b0, "R8 reset not ready", wrReady, 0);
    protoOn = 1'b1;

    // R3 register write
    misoQ = '{8'h00, 8'h00};
    payQ = '{8'hA5};
    runCmd(2'd0, 8'h05, 8'd0, 8'd0, 0, 0, "R3 regwr");

    // R4 register read
    misoQ = '{8'hFF, 8'h3C};
    payQ.delete();
    runCmd(2'd1, 8'h12, 8'd0, 8'd0, 0, 0, "R4 regrd");

    // R5 R8 buffer write with stall
    misoQ = '{8'h00};
    payQ = '{8'h81, 8'h7E, 8'h01};
    runCmd(2'd2, 8'h00, 8'd3, 8'd0, 7, 0, "R5 bufwr");

    // R5 empty buffer write
    payQ.delete();
    runCmd(2'd2, 8'h00, 8'd0, 8'd0, 0, 0, "R5 bufwr0");

    // R6 buffer read below capacity
    misoQ = '{8'h00, 8'd2, 8'h11, 8'h22, 8'hE7, 8'h99};
    runCmd(2'd3, 8'h00, 8'd0, 8'd10, 0, 0, "R6 bufrd");

    // R6 clamp to capacity
    misoQ = '{8'h00, 8'd9, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5};
    runCmd(2'd3, 8'h00, 8'd0, 8'd4, 0, 0, "R6 clamp");

    // R6 capacity zero
    misoQ = '{8'h00, 8'd5, 8'h55};
    runCmd(2'd3, 8'h00, 8'd0, 8'd0, 0, 0, "R6 cap0");

    // R6 maximum length
    misoQ.delete();
    misoQ.push_back(8'h00); misoQ.push_back(8'd255);
    for (int i = 0; i < 256; i++) misoQ.push_back(8'((i * 37 + 11) & 8'hFF));
    runCmd(2'd3, 8'h00, 8'd0, 8'd255, 0, 0, "R6 max");

    // R7 command while busy is ignored
    misoQ = '{8'h00, 8'h00};
    payQ = '{8'h5A};
    runCmd(2'd0, 8'h21, 8'd0, 8'd0, 0, 1, "R7 poke");

    // R9 interrupt synchroniser
    irqIn = 1'b1;
    @(negedge clk);
    check(irqSync == 1'b0, "R9 irq after one clock", irqSync, 0);
    @(negedge clk);
    check(irqSync == 1'b1, "R9 irq after two clocks", irqSync, 1);
    irqIn = 1'b0;
    @(negedge clk);
    check(irqSync == 1'b1, "R9 irq fall after one clock", irqSync, 1);
    @(negedge clk);
    check(irqSync == 1'b0, "R9 irq fall after two clocks", irqSync, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule